// File: doc/BRIEF.md
# Staged Control-Word Write Sequencer

This block loads a shared control register from a set of staged control words. A start pulse captures all words at once. The block then writes them one at a time in index order over a strobe-and-response target interface. Words below the last one normally tune one entropy cell each: one oscillator setting and the enable of that one cell. The last word installs the final operating state with every cell enabled. The sequencer moves the words through unchanged and does not look inside them.

The target answers every write strobe and every read strobe with a response code. An accepted write is followed by a readback poll of the register, which repeats until a read is accepted; only then does the next word begin. A busy refusal is retried after a fixed pause. A would-block refusal is retried after the tick count returned with it. Each kind of refusal has its own retry budget, and both budgets restart with every word. Running out of either budget, or receiving any unknown code, ends the sequence with an error code. A clean run ends with a one-cycle done pulse.

Top module: `cfg_write_seq`

## Requirements
- R1: After reset, `wr_stb_o`, `rd_stb_o` and `done_o` are low and `err_o` is 0.
- R2: A start pulse in idle captures `words_i`, where word k sits at bits [k*DATA_W +: DATA_W]. The words are written in index order 0 to N_WORDS-1, and `wr_data_o` equals the captured word during each write strobe. Later changes on `words_i` have no effect on the running sequence.
- R3: A response is taken only in the cycle after a strobe or later. Code 0 accepts the request. An accepted write is followed two cycles after its strobe by a read strobe for the same word. An accepted read starts the next word's write after the same two cycles. The two strobes are never high together, and each lasts one cycle.
- R4: `done_o` pulses for exactly one cycle, and only after the readback of the last word is accepted. When it does, `err_o` is 0.
- R5: Code 1 (busy) makes the block repeat the same strobe BUSY_DLY+2 cycles after the refused one. The BUSY_LIMIT-th busy response within one word stops the sequence with `err_o` = 1.
- R6: Code 2 (would-block) makes the block repeat the same strobe max(`rsp_ticks_i`,1)+2 cycles after the refused one. The BLOCK_LIMIT-th such response within one word stops the sequence with `err_o` = 2.
- R7: Codes 3 to 7 stop the sequence at once with `err_o` = 3. After any error no further strobes appear until the next start.
- R8: Both retry budgets restart at each new word, so every word may take up to BUSY_LIMIT-1 busy and BLOCK_LIMIT-1 would-block refusals without failing.
- R9: A start pulse during a running sequence is ignored. A start in idle clears `err_o` to 0 in the cycle after it is sampled.
- R10: A refusal of a readback read repeats the read, not the write, with the same spacing and the same budgets as refusals of writes.
- R11: `rsp_vld_i` is ignored while idle and in the cycle of a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled in idle |
| words_i | input | N_WORDS*DATA_W | Staged control words, word k at bits k*DATA_W upward |
| wr_stb_o | output | 1 | Register write strobe |
| wr_data_o | output | DATA_W | Data written with `wr_stb_o` |
| rd_stb_o | output | 1 | Readback poll strobe |
| rsp_vld_i | input | 1 | Target response valid |
| rsp_code_i | input | 3 | Response: 0 accept, 1 busy, 2 would-block, others unknown |
| rsp_ticks_i | input | TICK_W | Pause in cycles returned with a would-block response |
| done_o | output | 1 | One-cycle pulse on clean completion |
| err_o | output | 2 | 0 none, 1 busy limit, 2 would-block limit, 3 unknown code; held until next start |

## Verification
The bench builds the block with BUSY_LIMIT = 3, BLOCK_LIMIT = 4, BUSY_DLY = 2 and TICK_W = 8. With these small budgets, a run of a few dozen cycles can exhaust each budget and can also use the largest legal number of refusals on several words in a row. The small pause keeps the spacing of every retry short enough to check cycle by cycle. A returned tick count of zero exercises the one-cycle floor on the would-block pause.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

   typedef enum logic [1:0] {
      SEQ_ERR_NONE  = 2'd0,
      SEQ_ERR_BUSY  = 2'd1,
      SEQ_ERR_BLOCK = 2'd2,
      SEQ_ERR_NODEV = 2'd3
   } seq_err_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_HOLD  = 2'd3
   } seq_state_e;

   localparam logic [2:0] RSP_ACCEPT = 3'd0;
   localparam logic [2:0] RSP_BUSY   = 3'd1;
   localparam logic [2:0] RSP_BLOCK  = 3'd2;

endpackage

// File: rtl/cfgseq_stage.sv
module cfgseq_stage #(
   parameter int DATA_W  = 64,
   parameter int N_WORDS = 4,
   localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load_i,
   input  logic [N_WORDS*DATA_W-1:0] words_i,
   input  logic [IDX_W-1:0]          sel_i,
   output logic [DATA_W-1:0]         word_o
);

   logic [DATA_W-1:0] slot [N_WORDS];

   for (genvar g = 0; g < N_WORDS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot[g] <= '0;
         else if (load_i)
            slot[g] <= words_i[g*DATA_W +: DATA_W];
      end
   end

   always_comb begin
      word_o = slot[0];
      for (int i = 1; i < N_WORDS; i++) begin
         if (sel_i == IDX_W'(i))
            word_o = slot[i];
      end
   end

endmodule

// File: rtl/cfgseq_retry_ctr.sv
module cfgseq_retry_ctr #(
   parameter int LIMIT = 8,
   localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic hit_o
);

   logic [CNT_W-1:0] cnt;

   // hit_o flags the refusal that uses up the budget
   if (LIMIT == 1) begin : g_single
      assign hit_o = inc_i;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt <= '0;
         else
            cnt <= '0;
      end
   end else begin : g_count
      assign hit_o = inc_i && (cnt == CNT_W'(LIMIT - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt <= '0;
         else if (clr_i)
            cnt <= '0;
         else if (inc_i && !hit_o)
            cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/cfgseq_hold_timer.sv
module cfgseq_hold_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] value_i,
   input  logic             run_i,
   output logic             expire_o
);

   logic [CNT_W-1:0] remain;

   assign expire_o = run_i && (remain == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         remain <= '0;
      else if (load_i)
         remain <= value_i;
      else if (run_i && remain != '0)
         remain <= remain - 1'b1;
   end

endmodule

// File: rtl/cfg_write_seq.sv
module cfg_write_seq
   import cfgseq_pkg::*;
#(
   parameter int DATA_W      = 64,
   parameter int N_WORDS     = 4,
   parameter int BUSY_LIMIT  = 16,
   parameter int BLOCK_LIMIT = 16,
   parameter int BUSY_DLY    = 8,
   parameter int TICK_W      = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic [N_WORDS*DATA_W-1:0] words_i,
   output logic                      wr_stb_o,
   output logic [DATA_W-1:0]         wr_data_o,
   output logic                      rd_stb_o,
   input  logic                      rsp_vld_i,
   input  logic [2:0]                rsp_code_i,
   input  logic [TICK_W-1:0]         rsp_ticks_i,
   output logic                      done_o,
   output logic [1:0]                err_o
);

   localparam int IDX_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
   localparam int BDLY_W  = $clog2(BUSY_DLY + 1);
   localparam int DLY_W   = (BDLY_W > TICK_W) ? BDLY_W : TICK_W;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

   initial begin
      assert (DATA_W >= 1)      else $error("DATA_W must be at least 1");
      assert (N_WORDS >= 1)     else $error("N_WORDS must be at least 1");
      assert (BUSY_LIMIT >= 1)  else $error("BUSY_LIMIT must be at least 1");
      assert (BLOCK_LIMIT >= 1) else $error("BLOCK_LIMIT must be at least 1");
      assert (BUSY_DLY >= 1)    else $error("BUSY_DLY must be at least 1");
      assert (TICK_W >= 1)      else $error("TICK_W must be at least 1");
   end

   seq_state_e       state;
   seq_err_e         err_q;
   logic [IDX_W-1:0] idx;
   logic             rd_phase;

   logic load_words;
   logic take;
   logic is_ok, is_busy, is_block, is_other;
   logic busy_hit, block_hit;
   logic word_adv;
   logic retry_busy, retry_block;
   logic hold_expire;
   logic [DLY_W-1:0] hold_val;
   logic [DLY_W-1:0] tick_floor;

   // response decode
   assign take     = (state == ST_WAIT) && rsp_vld_i;
   assign is_ok    = (rsp_code_i == RSP_ACCEPT);
   assign is_busy  = (rsp_code_i == RSP_BUSY);
   assign is_block = (rsp_code_i == RSP_BLOCK);
   assign is_other = !(is_ok || is_busy || is_block);

   assign load_words  = (state == ST_IDLE) && start_i;
   assign word_adv    = take && is_ok && rd_phase && (idx != LAST_IDX);
   assign retry_busy  = take && is_busy && !busy_hit;
   assign retry_block = take && is_block && !block_hit;

   // staged words
   cfgseq_stage #(
      .DATA_W  (DATA_W),
      .N_WORDS (N_WORDS)
   ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_words),
      .words_i (words_i),
      .sel_i   (idx),
      .word_o  (wr_data_o)
   );

   // separate retry budgets, both restarted per word
   cfgseq_retry_ctr #(.LIMIT(BUSY_LIMIT)) u_busy_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (load_words || word_adv),
      .inc_i (take && is_busy),
      .hit_o (busy_hit)
   );

   cfgseq_retry_ctr #(.LIMIT(BLOCK_LIMIT)) u_block_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (load_words || word_adv),
      .inc_i (take && is_block),
      .hit_o (block_hit)
   );

   // pause length: fixed for busy, returned ticks (floor 1) for would-block
   if (DLY_W > TICK_W) begin : g_tick_wide
      assign tick_floor = (rsp_ticks_i == '0) ? DLY_W'(1)
                                              : {{(DLY_W-TICK_W){1'b0}}, rsp_ticks_i};
   end else begin : g_tick_same
      assign tick_floor = (rsp_ticks_i == '0) ? DLY_W'(1) : rsp_ticks_i;
   end

   assign hold_val = is_busy ? DLY_W'(BUSY_DLY) : tick_floor;

   cfgseq_hold_timer #(.CNT_W(DLY_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (retry_busy || retry_block),
      .value_i  (hold_val),
      .run_i    (state == ST_HOLD),
      .expire_o (hold_expire)
   );

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         err_q    <= SEQ_ERR_NONE;
         idx      <= '0;
         rd_phase <= 1'b0;
         done_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start_i) begin
                  state    <= ST_ISSUE;
                  idx      <= '0;
                  rd_phase <= 1'b0;
                  err_q    <= SEQ_ERR_NONE;
               end
            end
            ST_ISSUE: begin
               state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rsp_vld_i) begin
                  if (is_ok) begin
                     if (!rd_phase) begin
                        rd_phase <= 1'b1;
                        state    <= ST_ISSUE;
                     end else if (idx == LAST_IDX) begin
                        done_o <= 1'b1;
                        state  <= ST_IDLE;
                     end else begin
                        idx      <= idx + 1'b1;
                        rd_phase <= 1'b0;
                        state    <= ST_ISSUE;
                     end
                  end else if (is_busy) begin
                     if (busy_hit) begin
                        err_q <= SEQ_ERR_BUSY;
                        state <= ST_IDLE;
                     end else begin
                        state <= ST_HOLD;
                     end
                  end else if (is_block) begin
                     if (block_hit) begin
                        err_q <= SEQ_ERR_BLOCK;
                        state <= ST_IDLE;
                     end else begin
                        state <= ST_HOLD;
                     end
                  end else if (is_other) begin
                     err_q <= SEQ_ERR_NODEV;
                     state <= ST_IDLE;
                  end
               end
            end
            ST_HOLD: begin
               if (hold_expire)
                  state <= ST_ISSUE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign wr_stb_o = (state == ST_ISSUE) && !rd_phase;
   assign rd_stb_o = (state == ST_ISSUE) && rd_phase;
   assign err_o    = err_q;

endmodule

// File: rtl/cfgseq_checker.sv
module cfgseq_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_stb,
   input logic       rd_stb,
   input logic       rsp_vld,
   input logic [2:0] rsp_code,
   input logic       done,
   input logic [1:0] err
);

   // R3: write and read strobes never coincide
   p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && rd_stb));

   // R3: each strobe lasts one cycle
   p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);
   p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> !rd_stb);

   // R4: done is a clean single pulse following an accepted response
   p_done_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (err == 2'd0));
   p_done_after_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(rsp_vld && rsp_code == 3'd0));
   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5, R6, R7: each error code is caused by the matching response
   p_busy_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (err == 2'd1 && $past(err) != 2'd1) |-> $past(rsp_vld && rsp_code == 3'd1));
   p_block_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (err == 2'd2 && $past(err) != 2'd2) |-> $past(rsp_vld && rsp_code == 3'd2));
   p_nodev_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (err == 2'd3 && $past(err) != 2'd3) |-> $past(rsp_vld && rsp_code > 3'd2));

   // R7: no strobe while an error is held
   p_quiet_after_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (err != 2'd0) |-> (!wr_stb && !rd_stb));

endmodule

bind cfg_write_seq cfgseq_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_stb   (wr_stb_o),
   .rd_stb   (rd_stb_o),
   .rsp_vld  (rsp_vld_i),
   .rsp_code (rsp_code_i),
   .done     (done_o),
   .err      (err_o)
);

// File: tb/test_cfg_write_seq.sv
`timescale 1ns/1ps
module test_cfg_write_seq;

   localparam int DW = 64;
   localparam int NW = 4;
   localparam int BL = 3;
   localparam int KL = 4;
   localparam int BD = 2;
   localparam int TW = 8;

   typedef struct {
      int          code;
      int          ticks;
      bit          stray;
   } rsp_t;

   typedef struct {
      bit          rd;
      logic [DW-1:0] data;
      int          gap;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [NW*DW-1:0]  words_i = '0;
   logic              wr_stb_o, rd_stb_o, done_o;
   logic [DW-1:0]     wr_data_o;
   logic              rsp_vld_i = 1'b0;
   logic [2:0]        rsp_code_i = '0;
   logic [TW-1:0]     rsp_ticks_i = '0;
   logic [1:0]        err_o;

   int   n_chk = 0;
   int   n_fail = 0;
   int   cyc = 0;
   int   last_stb = 0;
   int   done_cnt = 0;
   bit   prev_done = 0;
   bit   pend = 0;
   bit   idle_poke = 0;
   bit   finished = 0;
   rsp_t pend_rsp;
   rsp_t script_q[$];
   exp_t exp_q[$];
   int   exp_err;
   bit   exp_done;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cfg_write_seq #(
      .DATA_W(DW), .N_WORDS(NW), .BUSY_LIMIT(BL), .BLOCK_LIMIT(KL),
      .BUSY_DLY(BD), .TICK_W(TW)
   ) i_cfg_write_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .words_i(words_i),
      .wr_stb_o(wr_stb_o), .wr_data_o(wr_data_o), .rd_stb_o(rd_stb_o),
      .rsp_vld_i(rsp_vld_i), .rsp_code_i(rsp_code_i), .rsp_ticks_i(rsp_ticks_i),
      .done_o(done_o), .err_o(err_o)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   // target model and monitor: pops expected strobes, answers from the script
   initial begin
      forever begin
         @(negedge clk);
         rsp_vld_i = 1'b0;
         if (done_o) begin
            done_cnt++;
            chk(!prev_done, "R4", "done wider than one cycle", 1, 0);
         end
         prev_done = done_o;
         if (idle_poke) begin
            rsp_vld_i  = 1'b1;
            rsp_code_i = 3'd3;
            idle_poke  = 0;
         end
         if (pend) begin
            rsp_vld_i   = 1'b1;
            rsp_code_i  = 3'(pend_rsp.code);
            rsp_ticks_i = TW'(pend_rsp.ticks);
            pend = 0;
         end
         if (wr_stb_o || rd_stb_o) begin
            if (exp_q.size() == 0 || script_q.size() == 0) begin
               chk(0, "R7", "unexpected strobe", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               pend_rsp = script_q.pop_front();
               chk(rd_stb_o == e.rd, "R3/R10", "strobe kind (1=read)", rd_stb_o, e.rd);
               if (!e.rd)
                  chk(wr_data_o == e.data, "R2", "write data", wr_data_o, e.data);
               if (e.gap >= 0)
                  chk((cyc - last_stb) == e.gap, "R3/R5/R6", "strobe spacing",
                      cyc - last_stb, e.gap);
               pend = 1;
               if (pend_rsp.stray) begin
                  rsp_vld_i  = 1'b1;
                  rsp_code_i = 3'd3;
               end
            end
            last_stb = cyc;
         end
      end
   end

   function automatic logic [DW-1:0] mkword(input int k, input logic [31:0] seed);
      return {seed ^ 32'(k * 32'h9E37), 16'(k + 1), 12'h0, 4'(1 << (k % 3)),
              8'(k), 8'h5A};
   endfunction

   task automatic push(input int code, input int ticks = 0, input bit stray = 0);
      rsp_t r;
      r.code = code; r.ticks = ticks; r.stray = stray;
      script_q.push_back(r);
   endtask

   // bench-side sequence model built from the requirements
   task automatic plan_run(input logic [NW*DW-1:0] w);
      int idx = 0, b = 0, k = 0, gap = -1;
      bit rd = 0;
      exp_q.delete();
      exp_err = 0;
      exp_done = 0;
      for (int i = 0; i < script_q.size(); i++) begin
         exp_t e;
         e.rd = rd; e.data = w[idx*DW +: DW]; e.gap = gap;
         exp_q.push_back(e);
         if (script_q[i].code == 0) begin
            gap = 2;
            if (!rd) rd = 1;
            else if (idx == NW - 1) begin exp_done = 1; break; end
            else begin idx++; rd = 0; b = 0; k = 0; end
         end else if (script_q[i].code == 1) begin
            b++;
            if (b == BL) begin exp_err = 1; break; end
            gap = 2 + BD;
         end else if (script_q[i].code == 2) begin
            k++;
            if (k == KL) begin exp_err = 2; break; end
            gap = 2 + ((script_q[i].ticks == 0) ? 1 : script_q[i].ticks);
         end else begin
            exp_err = 3;
            break;
         end
      end
   endtask

   task automatic run_seq(input logic [31:0] seed, input bit poke, input string tag);
      logic [NW*DW-1:0] w;
      for (int i = 0; i < NW; i++) w[i*DW +: DW] = mkword(i, seed);
      plan_run(w);
      done_cnt = 0;
      @(negedge clk);
      words_i = w;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(err_o == 2'd0, "R9", "error cleared by start", err_o, 0);
      if (poke) begin
         repeat (3) @(negedge clk);
         words_i = ~w;
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
      end
      for (int t = 0; t < 3000; t++) begin
         @(negedge clk);
         if (done_cnt != 0 || err_o != 2'd0) break;
      end
      repeat (15) @(negedge clk);
      chk(exp_q.size() == 0, tag, "missing strobes", exp_q.size(), 0);
      chk(err_o == 2'(exp_err), tag, "error code", err_o, exp_err);
      chk(done_cnt == (exp_done ? 1 : 0), tag, "done pulses", done_cnt, exp_done);
      script_q.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!wr_stb_o && !rd_stb_o, "R1", "strobes in reset", {wr_stb_o, rd_stb_o}, 0);
      chk(!done_o && err_o == 2'd0, "R1", "done/err in reset", {done_o, err_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!wr_stb_o && !rd_stb_o && err_o == 0, "R1", "idle after reset",
          {wr_stb_o, rd_stb_o, err_o}, 0);

      // R2 R3 R4: clean run
      for (int i = 0; i < 2 * NW; i++) push(0);
      run_seq(32'hA5A5_0001, 0, "R4");

      // R5 R6 R8: refusal budgets just under their limits on several words
      push(1); push(1); push(0); push(0);
      push(2, 0); push(2, 5); push(2, 1); push(0); push(0);
      push(1); push(2, 3); push(1); push(0); push(0);
      push(0); push(0);
      run_seq(32'h1234_5678, 0, "R8");

      // R10: refusals on readback polls
      push(0); push(1); push(2, 2); push(0);
      push(0); push(1); push(1); push(0);
      push(0); push(0);
      push(0); push(2, 0); push(0);
      run_seq(32'h0BAD_F00D, 0, "R10");

      // R5: busy limit on word 1
      push(0); push(0); push(1); push(1); push(1);
      run_seq(32'h0000_0055, 0, "R5");

      // R6 R9: would-block limit on word 0, after the start cleared the error
      push(2, 1); push(2, 4); push(2, 0); push(2, 2);
      run_seq(32'hCAFE_0002, 0, "R6");

      // R7: unknown code aborts
      push(0); push(0); push(5);
      run_seq(32'h7777_0003, 0, "R7");

      // R9 R2 R11: mid-run start and input change ignored, strays ignored
      push(0, 0, 1); push(0);
      push(0, 0, 1); push(0, 0, 1);
      push(0); push(0); push(0); push(0);
      run_seq(32'h3141_5926, 1, "R9/R11");

      // R11: stray response while idle
      idle_poke = 1;
      repeat (6) @(negedge clk);
      chk(err_o == 2'd0, "R11", "idle stray response", err_o, 0);
      chk(!wr_stb_o && !rd_stb_o, "R11", "no strobe from idle stray",
          {wr_stb_o, rd_stb_o}, 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule